// File: doc/BRIEF.md
# Unlock-Protected Mode Control Register

This block is an 8-bit control register on a processor's peripheral bus. It holds two system mode bits: a code-memory swap bit and a boot-loader enable bit. Software cannot simply write these bits. A new mode is accepted only when an arming write is followed by a confirming write. The new mode then takes effect after a fixed number of instruction boundaries. A write that tries to change a mode bit outside this sequence shows in the readback for a short time. The bit then returns to its effective value, and the mode outputs never move.

The processor supplies a one-cycle `instr_end` strobe at every instruction boundary. All delays in the block are counted on this strobe. The block also drives an interrupt-block line. The line pulses for one cycle at the start of the instruction that follows any access to the register. It is held high from the arming write until the new mode is active, so the sequence cannot be interrupted.

Top module: `unlock_mode_reg`

## Requirements
- R1: A synchronous reset clears both mode outputs, both sequence flags, the readback register, the interrupt-block line and the sequence state.
- R2: The register reads back as follows: bit 7 is the unlock flag, bit 6 is the confirm flag, bit 2 is the boot-loader bit and bit 0 is the swap bit. Bits 5, 4, 3 and 1 read as zero. `rdata` holds the value in the cycle after `rd_en`.
- R3: A write with bit 7 low, or with bits 7 and 6 both high outside the armed state, clears both flags. The written mode bits appear in the readback and are restored to the effective mode on the second `instr_end` after the write. The mode outputs do not change.
- R4: A write with bit 7 high and bit 6 low is an arming write. It sets the unlock flag, stages its mode bits and shows them in the readback. A repeated arming write replaces the staged value.
- R5: In the armed state, a write with bits 7 and 6 both high confirms the sequence. The mode staged by the arming write is applied, and the mode bits of the confirming write are ignored. The mode outputs change on the second `instr_end` after the confirming write. An `instr_end` in the same cycle as the write is not counted. When the new mode becomes active, both flags clear.
- R6: In the armed state, a write that is neither a confirm nor an arming write aborts the sequence. Both flags clear, the readback mode bits return at once to the effective mode, and the mode outputs do not change.
- R7: An arming write with both mode bits set, once confirmed, switches both mode outputs on the same cycle.
- R8: While a confirmed change is counting down, further writes have no effect on the readback or on the pending mode.
- R9: After any read or write of the register, `irq_block` is high for exactly the one cycle that follows the next `instr_end`.
- R10: `irq_block` is high for the whole time the sequence is armed or counting down to activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe to this register |
| rd_en | input | 1 | Bus read strobe to this register |
| wdata | input | 8 | Write data |
| instr_end | input | 1 | One-cycle strobe at each instruction boundary |
| rdata | output | 8 | Registered readback value |
| mode_swap | output | 1 | Effective code-memory swap mode |
| mode_boot | output | 1 | Effective boot-loader enable mode |
| irq_block | output | 1 | Interrupt acceptance block |

## Verification
Readback is due one cycle after `rd_en`. Flag and readback changes from a write are visible one cycle after the write. Mode activation and bit restore take place on the edge of the second counted `instr_end`, and the interrupt-block pulse is high in the cycle after the qualifying `instr_end`. The bench drives every stimulus for one full cycle from a falling edge and samples at the following falling edge, after the single register stage has settled. Mode outputs are compared after each instruction boundary, so a change one boundary early or late is reported. The directed part covers a write and an `instr_end` in the same cycle, an aborted sequence, the interrupt-block pulse and hold, and a reset in the middle of a countdown.

// File: rtl/umr_pkg.sv
package umr_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_UNLOCK  = 7;
  localparam int BIT_CONFIRM = 6;
  localparam int BIT_BOOT    = 2;
  localparam int BIT_SWAP    = 0;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_PENDING = 2'd2,
    ST_REVERT  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic boot;
    logic swap;
  } mode_t;
endpackage

// File: rtl/umr_instr_count.sv
module umr_instr_count #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // a tick arriving together with a load is not counted
  assign expire = tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/umr_seq_ctrl.sv
module umr_seq_ctrl
  import umr_pkg::*;
#(
  parameter int CNT_W        = 2,
  parameter int ACT_DELAY    = 2,
  parameter int REVERT_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_unlock,
  input  logic             wr_confirm,
  input  mode_t            wr_mode,
  input  logic             expire,
  output seq_state_t       state,
  output mode_t            eff_mode,
  output mode_t            shown_mode,
  output logic             flag_unlock,
  output logic             flag_confirm,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  seq_state_t st_q, st_n;
  mode_t      eff_q, eff_n, shown_q, shown_n, staged_q, staged_n;
  logic       unl_q, unl_n, cnf_q, cnf_n;

  logic arm_wr, confirm_wr;
  assign arm_wr     = wr_unlock && !wr_confirm;
  assign confirm_wr = wr_unlock && wr_confirm;

  always_comb begin
    st_n     = st_q;
    eff_n    = eff_q;
    shown_n  = shown_q;
    staged_n = staged_q;
    unl_n    = unl_q;
    cnf_n    = cnf_q;
    load     = 1'b0;
    load_val = '0;
    if (wr_en && st_q != ST_PENDING) begin
      if (st_q == ST_ARMED && confirm_wr) begin
        st_n     = ST_PENDING;
        cnf_n    = 1'b1;
        load     = 1'b1;
        load_val = CNT_W'(ACT_DELAY);
      end else if (arm_wr) begin
        st_n     = ST_ARMED;
        staged_n = wr_mode;
        shown_n  = wr_mode;
        unl_n    = 1'b1;
        cnf_n    = 1'b0;
      end else if (st_q == ST_ARMED) begin
        // broken sequence: drop it at once
        st_n    = ST_IDLE;
        shown_n = eff_q;
        unl_n   = 1'b0;
        cnf_n   = 1'b0;
      end else begin
        unl_n   = 1'b0;
        cnf_n   = 1'b0;
        shown_n = wr_mode;
        if (wr_mode != eff_q) begin
          st_n     = ST_REVERT;
          load     = 1'b1;
          load_val = CNT_W'(REVERT_DELAY);
        end else begin
          st_n = ST_IDLE;
        end
      end
    end else if (expire) begin
      if (st_q == ST_PENDING) begin
        eff_n   = staged_q;
        shown_n = staged_q;
        unl_n   = 1'b0;
        cnf_n   = 1'b0;
        st_n    = ST_IDLE;
      end else if (st_q == ST_REVERT) begin
        shown_n = eff_q;
        st_n    = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      eff_q    <= '0;
      shown_q  <= '0;
      staged_q <= '0;
      unl_q    <= 1'b0;
      cnf_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      eff_q    <= eff_n;
      shown_q  <= shown_n;
      staged_q <= staged_n;
      unl_q    <= unl_n;
      cnf_q    <= cnf_n;
    end
  end

  assign state        = st_q;
  assign eff_mode     = eff_q;
  assign shown_mode   = shown_q;
  assign flag_unlock  = unl_q;
  assign flag_confirm = cnf_q;
endmodule

// File: rtl/umr_irq_guard.sv
module umr_irq_guard (
  input  logic clk,
  input  logic rst,
  input  logic access,
  input  logic instr_end,
  input  logic seq_hold,
  output logic irq_block
);
  logic owed_q, pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= instr_end && (owed_q || access);
      owed_q  <= (owed_q || access) && !instr_end;
    end
  end

  assign irq_block = pulse_q || seq_hold;
endmodule

// File: rtl/unlock_mode_reg.sv
module unlock_mode_reg
  import umr_pkg::*;
#(
  parameter int ACT_DELAY    = 2,
  parameter int REVERT_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             instr_end,
  output logic [REG_W-1:0] rdata,
  output logic             mode_swap,
  output logic             mode_boot,
  output logic             irq_block
);
  localparam int MAX_DELAY = (ACT_DELAY > REVERT_DELAY) ? ACT_DELAY : REVERT_DELAY;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  seq_state_t       st;
  mode_t            eff_mode, shown_mode, wr_mode;
  logic             flag_unlock, flag_confirm, load, expire;
  logic [CNT_W-1:0] load_val;
  logic [REG_W-1:0] reg_view, rdata_q;
  logic             unused_bits;

  assign wr_mode     = '{boot: wdata[BIT_BOOT], swap: wdata[BIT_SWAP]};
  assign unused_bits = ^{wdata[5:3], wdata[1]};

  umr_seq_ctrl #(
    .CNT_W(CNT_W), .ACT_DELAY(ACT_DELAY), .REVERT_DELAY(REVERT_DELAY)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_unlock(wdata[BIT_UNLOCK]), .wr_confirm(wdata[BIT_CONFIRM]),
    .wr_mode(wr_mode), .expire(expire), .state(st),
    .eff_mode(eff_mode), .shown_mode(shown_mode),
    .flag_unlock(flag_unlock), .flag_confirm(flag_confirm),
    .load(load), .load_val(load_val)
  );

  umr_instr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .tick(instr_end), .expire(expire)
  );

  umr_irq_guard u_irq (
    .clk(clk), .rst(rst), .access(wr_en || rd_en), .instr_end(instr_end),
    .seq_hold(st == ST_ARMED || st == ST_PENDING), .irq_block(irq_block)
  );

  always_comb begin
    reg_view              = '0;
    reg_view[BIT_UNLOCK]  = flag_unlock;
    reg_view[BIT_CONFIRM] = flag_confirm;
    reg_view[BIT_BOOT]    = shown_mode.boot;
    reg_view[BIT_SWAP]    = shown_mode.swap;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= reg_view;
  end

  assign rdata     = rdata_q;
  assign mode_swap = eff_mode.swap;
  assign mode_boot = eff_mode.boot;
endmodule

// File: rtl/umr_checker.sv
module umr_checker
  import umr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [REG_W-1:0] wdata,
  input logic             instr_end,
  input logic [REG_W-1:0] rdata,
  input logic             mode_swap,
  input logic             mode_boot,
  input logic             irq_block,
  input seq_state_t       st
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!mode_swap && !mode_boot && !irq_block && rdata == '0 && st == ST_IDLE));

  assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rdata[5:3] == 3'b000 && rdata[1] == 1'b0));

  assert_mode_only_from_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (st != ST_PENDING) |=> $stable({mode_boot, mode_swap}));

  assert_confirm_enters_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == ST_ARMED && wdata[7] && wdata[6]) |=> (st == ST_PENDING));

  assert_pending_ignores_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == ST_PENDING && !instr_end) |=> (st == ST_PENDING));

  assert_access_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (instr_end && (rd_en || wr_en)) |=> irq_block);

  assert_sequence_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED || st == ST_PENDING) |-> irq_block);
endmodule

bind unlock_mode_reg umr_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .instr_end(instr_end), .rdata(rdata), .mode_swap(mode_swap),
  .mode_boot(mode_boot), .irq_block(irq_block), .st(st)
);

// File: tb/unlock_mode_reg_test.sv
module unlock_mode_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;
  localparam logic [1:0] OP_WR = 2'd0, OP_IE = 2'd1;

  // {op, data, expected {boot,swap}, expected readback}
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {OP_WR, 8'h05, 2'b00, 8'h05},
    {OP_IE, 8'h00, 2'b00, 8'h05},
    {OP_IE, 8'h00, 2'b00, 8'h00},
    {OP_WR, 8'h81, 2'b00, 8'h81},
    {OP_WR, 8'hC4, 2'b00, 8'hC1},
    {OP_IE, 8'h00, 2'b00, 8'hC1},
    {OP_IE, 8'h00, 2'b01, 8'h01},
    {OP_WR, 8'h85, 2'b01, 8'h85},
    {OP_WR, 8'h04, 2'b01, 8'h01},
    {OP_IE, 8'h00, 2'b01, 8'h01},
    {OP_WR, 8'h84, 2'b01, 8'h84},
    {OP_WR, 8'hC0, 2'b01, 8'hC4},
    {OP_WR, 8'h00, 2'b01, 8'hC4},
    {OP_IE, 8'h00, 2'b01, 8'hC4},
    {OP_IE, 8'h00, 2'b10, 8'h04},
    {OP_WR, 8'h85, 2'b10, 8'h85},
    {OP_WR, 8'hC5, 2'b10, 8'hC5},
    {OP_IE, 8'h00, 2'b10, 8'hC5},
    {OP_IE, 8'h00, 2'b11, 8'h05},
    {OP_WR, 8'h40, 2'b11, 8'h00},
    {OP_IE, 8'h00, 2'b11, 8'h00},
    {OP_IE, 8'h00, 2'b11, 8'h05}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, instr_end = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       mode_swap, mode_boot, irq_block;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_mode_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .instr_end(instr_end), .rdata(rdata), .mode_swap(mode_swap),
    .mode_boot(mode_boot), .irq_block(irq_block)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic with_ie);
    @(negedge clk);
    wr_en = 1'b1; wdata = d; instr_end = with_ie;
    @(negedge clk);
    wr_en = 1'b0; instr_end = 1'b0;
  endtask

  task automatic do_ie();
    @(negedge clk);
    instr_end = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check("R1 modes", {6'b0, mode_boot, mode_swap}, 8'h00);
    check("R1 irq_block", {7'b0, irq_block}, 8'h00);
    check("R1 rdata", rdata, 8'h00);

    // R2 R3 R4 R5 R6 R7 R8: table walk, modes then readback after every step
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19:18] == OP_WR) do_write(VEC[i][17:10], 1'b0);
      else do_ie();
      check($sformatf("R3 R5 R7 R8 modes step %0d", i),
            {6'b0, mode_boot, mode_swap}, {6'b0, VEC[i][9:8]});
      do_read(rv);
      check($sformatf("R2 R4 R6 readback step %0d", i), rv, VEC[i][7:0]);
    end

    // R9: read then an instruction boundary gives a one-cycle block
    do_read(rv);
    do_ie();
    check("R9 pulse high", {7'b0, irq_block}, 8'h01);
    @(negedge clk);
    check("R9 pulse ends", {7'b0, irq_block}, 8'h00);

    // R10: held while armed, released on abort (R6)
    do_write(8'h80, 1'b0);
    check("R10 held armed", {7'b0, irq_block}, 8'h01);
    @(negedge clk);
    check("R10 still held", {7'b0, irq_block}, 8'h01);
    do_write(8'h10, 1'b0);
    check("R6 abort releases", {7'b0, irq_block}, 8'h00);
    check("R6 abort modes kept", {6'b0, mode_boot, mode_swap}, 8'h03);

    // R1: reset in the middle of a countdown
    do_write(8'h80, 1'b0);
    do_write(8'hC0, 1'b0);
    check("R10 held pending", {7'b0, irq_block}, 8'h01);
    do_ie();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid reset modes", {6'b0, mode_boot, mode_swap}, 8'h00);
    check("R1 mid reset irq", {7'b0, irq_block}, 8'h00);
    do_ie(); do_ie();
    check("R1 no late activation", {6'b0, mode_boot, mode_swap}, 8'h00);
    do_read(rv);
    check("R1 mid reset readback", rv, 8'h00);

    // R5: boundary in the same cycle as the confirm is not counted
    do_write(8'h81, 1'b1);
    do_write(8'hC0, 1'b1);
    do_ie();
    check("R5 one boundary", {6'b0, mode_boot, mode_swap}, 8'h00);
    do_ie();
    check("R5 second boundary", {6'b0, mode_boot, mode_swap}, 8'h01);
    do_read(rv);
    check("R5 flags cleared", rv, 8'h01);

    // R4: repeated arming write replaces staged value
    do_write(8'h81, 1'b0);
    do_write(8'h84, 1'b0);
    do_write(8'hC1, 1'b0);
    do_ie(); do_ie();
    check("R4 restaged mode", {6'b0, mode_boot, mode_swap}, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule